// File: doc/BRIEF.md
# Control Memory Pseudorandom Fill Engine

This block fills a contiguous window of a word-wide control memory with pseudorandom words, so that a host does not have to write each location one by one. The host supplies a first and last address, a seed, a per-bit update mask, a force-one mask and a force-zero mask. It then raises an enable level. On the rising edge of that level the engine captures the whole setup. It then walks the window in ascending order and writes one shaped word per address. While it runs, `busy_o` is high and `done_o` is low.

The memory is reached through one plain synchronous RAM port with a read latency of one cycle. Bits that must not change are preserved by a read-modify-write: each address is read in one cycle and written in the next. The pseudorandom source is a Galois LFSR. It is loaded with the seed and advanced once for each address written. The logic that normally reads this memory is assumed to be halted while a fill runs.

Top module: `cm_fill_engine`

## Requirements
- R1: A fill starts only on a rising edge of `enable_i`, seen at a clock edge while the engine is idle. The engine is busy from the next cycle. Holding `enable_i` high starts nothing further. A rising edge that arrives while a fill runs is ignored, even when it falls in the cycle of the final write.
- R2: Every address from the first address to the last address, both included, is written exactly once, in ascending order. No address outside the window is written.
- R3: The pseudorandom word for the k-th address of the window (k = 0 for the first address) is the seed advanced k times. One advance is `s = s[0] ? (s >> 1) ^ 32'h80200003 : s >> 1`, which is the polynomial x^32+x^22+x^2+x+1.
- R4: The shaped word is `(prn | or_mask_i) & and_mask_i`. Where both masks act on the same bit, the bit is 0.
- R5: Bits whose `bit_en_i` bit is 0 keep their previous memory contents. Bits whose `bit_en_i` bit is 1 take the shaped word. Each write is preceded, in the previous cycle, by a read of the same address.
- R6: Out of reset, `done_o` is 1, `busy_o` is 0 and the memory port is quiet. `done_o` is 0 exactly while `busy_o` is 1. Both return to their idle values in the cycle after the last write.
- R7: If the last address is below the first address, a rising edge causes no memory access, and `done_o` stays 1 throughout.
- R8: The window, seed and masks are captured on the starting edge. Changes to these inputs during a fill have no effect on the words written.
- R9: A fill of N addresses keeps `busy_o` high for exactly 2N cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Fill request level; a rising edge starts a run |
| start_addr_i | input | ADDR_W | First address of the window |
| end_addr_i | input | ADDR_W | Last address of the window (inclusive) |
| seed_i | input | DATA_W | LFSR seed |
| bit_en_i | input | DATA_W | Per-bit update enable |
| or_mask_i | input | DATA_W | Bits forced to 1 |
| and_mask_i | input | DATA_W | Bits kept (0 forces the bit to 0, and wins over the OR mask) |
| busy_o | output | 1 | Fill in progress |
| done_o | output | 1 | Idle / fill complete |
| mem_req_o | output | 1 | Memory access strobe |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, valid one cycle after a read |

## Verification
Two events can land on the same clock edge: a fresh rising edge of `enable_i`, and the final write of a running fill. The bench drops `enable_i` one cycle before the last write and raises it again on the last write edge. It then expects the fill to end normally, with no second run, no extra memory access and `done_o` held at 1 afterwards. A second coincidence is also provoked: the window, seed and masks are scrambled in the first busy cycle, while the captured copies are in use. Every memory word is then compared with a model built from the inputs as they were at the starting edge.

// File: rtl/cm_fill_pkg.sv
package cm_fill_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } fill_st_e;

  localparam logic [31:0] LFSR_TAPS_32 = 32'h8020_0003;
endpackage

// File: rtl/cm_fill_lfsr.sv
module cm_fill_lfsr #(
  parameter int          W    = 32,
  parameter logic [W-1:0] TAPS = W'(32'h8020_0003)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] seed_i,
  input  logic         adv_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q, state_nxt;

  always_comb begin
    state_nxt = state_q >> 1;
    if (state_q[0]) state_nxt = state_nxt ^ TAPS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= '0;
    else if (load_i) state_q <= seed_i;
    else if (adv_i)  state_q <= state_nxt;
  end

  assign state_o = state_q;

  // R3
  lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !adv_i) |=> $stable(state_q));
  // R3
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !load_i && state_q != '0) |=> state_q != '0);
endmodule

// File: rtl/cm_fill_merge.sv
module cm_fill_merge #(
  parameter int W = 32
) (
  input  logic [W-1:0] prn_i,
  input  logic [W-1:0] old_i,
  input  logic [W-1:0] or_i,
  input  logic [W-1:0] and_i,
  input  logic [W-1:0] bit_en_i,
  output logic [W-1:0] word_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic shaped;
    assign shaped    = (prn_i[b] | or_i[b]) & and_i[b];
    assign word_o[b] = bit_en_i[b] ? shaped : old_i[b];
  end

  always_comb begin
    // R5
    keep_bits_chk: assert (((word_o ^ old_i) & ~bit_en_i) == '0);
    // R4
    and_wins_chk: assert ((word_o & ~and_i & bit_en_i) == '0);
  end
endmodule

// File: rtl/cm_fill_seq.sv
module cm_fill_seq
  import cm_fill_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          enable_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  output logic          load_o,
  output logic          adv_o,
  output logic          req_o,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic          busy_o,
  output logic          done_o
);
  fill_st_e      st_q;
  logic          en_q, done_q, last;
  logic [AW-1:0] addr_q, lo_q, hi_q;
  logic          rise, go;

  assign rise = enable_i & ~en_q;
  // empty window is swallowed here: no state change, done stays high
  assign go   = rise && (st_q == ST_IDLE) && (end_i >= start_i);
  assign last = (addr_q == hi_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= enable_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
      done_q <= 1'b1;
    end else begin
      unique case (st_q)
        ST_IDLE: if (go) begin
          st_q   <= ST_RD;
          addr_q <= start_i;
          lo_q   <= start_i;
          hi_q   <= end_i;
          done_q <= 1'b0;
        end
        ST_RD: st_q <= ST_WR;
        ST_WR: begin
          if (last) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            st_q   <= ST_RD;
            addr_q <= AW'(addr_q + 1'b1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign load_o = go;
  assign adv_o  = (st_q == ST_WR) && !last;
  assign req_o  = (st_q != ST_IDLE);
  assign we_o   = (st_q == ST_WR);
  assign addr_o = addr_q;
  assign busy_o = (st_q != ST_IDLE);
  assign done_o = done_q;

  // R5
  rmw_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> ($past(req_o && !we_o) && addr_o == $past(addr_o)));
  // R2
  win_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> (addr_o >= lo_q && addr_o <= hi_q));
  // R2
  ascend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_o && !last) |=> ##1 (we_o && addr_o == AW'($past(addr_o, 2) + 1'b1)));
  // R6
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !done_o);
  // R1
  start_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(enable_i));
endmodule

// File: rtl/cm_fill_engine.sv
module cm_fill_engine
  import cm_fill_pkg::*;
#(
  parameter int          ADDR_W = 10,
  parameter int          DATA_W = 32,
  parameter logic [DATA_W-1:0] TAPS = DATA_W'(LFSR_TAPS_32)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] end_addr_i,
  input  logic [DATA_W-1:0] seed_i,
  input  logic [DATA_W-1:0] bit_en_i,
  input  logic [DATA_W-1:0] or_mask_i,
  input  logic [DATA_W-1:0] and_mask_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic              load, adv;
  logic [DATA_W-1:0] prn, or_q, and_q, ben_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      or_q  <= '0;
      and_q <= '0;
      ben_q <= '0;
    end else if (load) begin
      or_q  <= or_mask_i;
      and_q <= and_mask_i;
      ben_q <= bit_en_i;
    end
  end

  cm_fill_seq #(.AW(ADDR_W)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enable_i (enable_i),
    .start_i  (start_addr_i),
    .end_i    (end_addr_i),
    .load_o   (load),
    .adv_o    (adv),
    .req_o    (mem_req_o),
    .we_o     (mem_we_o),
    .addr_o   (mem_addr_o),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  cm_fill_lfsr #(.W(DATA_W), .TAPS(TAPS)) i_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .seed_i  (seed_i),
    .adv_i   (adv),
    .state_o (prn)
  );

  cm_fill_merge #(.W(DATA_W)) i_merge (
    .prn_i    (prn),
    .old_i    (mem_rdata_i),
    .or_i     (or_q),
    .and_i    (and_q),
    .bit_en_i (ben_q),
    .word_o   (mem_wdata_o)
  );

  // R6
  quiet_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);
endmodule

// File: tb/test_cm_fill_engine.sv
module test_cm_fill_engine;
  localparam int AW = 6;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0;
  logic [AW-1:0] s_addr = '0, e_addr = '0;
  logic [DW-1:0] seed = '0, ben = '0, orm = '0, andm = '0;
  logic busy, done, req, we;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;

  int total = 0, bad = 0, cycles = 0;
  logic [DW-1:0] mem [DEPTH];
  int wcnt [DEPTH];
  int acc = 0;
  logic pre_go = 1'b0;
  int pre_key = 0;
  logic [DW-1:0] expv [DEPTH];

  always #10 clk = ~clk;

  cm_fill_engine #(.ADDR_W(AW), .DATA_W(DW)) i_cm_fill_engine (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable),
    .start_addr_i(s_addr), .end_addr_i(e_addr), .seed_i(seed),
    .bit_en_i(ben), .or_mask_i(orm), .and_mask_i(andm),
    .busy_o(busy), .done_o(done), .mem_req_o(req), .mem_we_o(we),
    .mem_addr_o(addr), .mem_wdata_o(wdata), .mem_rdata_i(rdata)
  );

  function automatic logic [DW-1:0] pat(int i, int key);
    return DW'(32'h9E37_79B9 * (i + key + 1)) ^ DW'(key * 32'h0101_0101);
  endfunction

  function automatic logic [DW-1:0] step(logic [DW-1:0] s);
    return s[0] ? ((s >> 1) ^ 32'h8020_0003) : (s >> 1);
  endfunction

  always @(posedge clk) begin
    if (pre_go) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem[i]  <= pat(i, pre_key);
        wcnt[i] <= 0;
      end
      acc <= 0;
    end else if (req) begin
      acc <= acc + 1;
      if (we) begin
        mem[addr]  <= wdata;
        wcnt[addr] <= wcnt[addr] + 1;
      end else rdata <= mem[addr];
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string req_tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  // disturb: 0 none, 1 scramble config in first busy cycle (R8),
  // 2 re-rise while busy (R1), 3 re-rise on last write edge (R1)
  task automatic run_fill(int s, int e, logic [DW-1:0] sd, logic [DW-1:0] b,
                          logic [DW-1:0] o, logic [DW-1:0] a, int key, int disturb);
    int n, bcnt;
    logic [DW-1:0] p, w;
    n = (e >= s) ? (e - s + 1) : 0;
    @(negedge clk); pre_key = key; pre_go = 1'b1;
    @(negedge clk); pre_go = 1'b0;
    for (int i = 0; i < DEPTH; i++) expv[i] = pat(i, key);
    p = sd;
    for (int i = s; i <= e; i++) begin
      w = (p | o) & a;
      expv[i] = (expv[i] & ~b) | (w & b);
      p = step(p);
    end
    s_addr = AW'(s); e_addr = AW'(e); seed = sd; ben = b; orm = o; andm = a;
    enable = 1'b1;
    bcnt = 0;
    for (int g = 0; g < 4 * DEPTH + 8; g++) begin
      @(negedge clk);
      if (!busy) break;
      bcnt++;
      if (disturb == 1 && bcnt == 1) begin
        s_addr = ~s_addr; e_addr = '1; seed = ~seed; ben = '1; orm = 32'h5A5A_A5A5; andm = '1;
      end
      if (disturb == 2 && bcnt == 2) enable = 1'b0;
      if (disturb == 2 && bcnt == 3) enable = 1'b1;
      if (disturb == 3 && bcnt == 2 * n - 1) enable = 1'b0;
      if (disturb == 3 && bcnt == 2 * n) enable = 1'b1;
    end
    chk("R9 busy cycles", 64'(bcnt), 64'(2 * n));
    chk("R6 done after fill", 64'(done), 64'd1);
    for (int i = 0; i < DEPTH; i++) begin
      chk($sformatf("R2/R3/R4/R5/R8 word @%0d", i), 64'(mem[i]), 64'(expv[i]));
      chk($sformatf("R2 write count @%0d", i), 64'(wcnt[i]), 64'((i >= s && i <= e) ? 1 : 0));
    end
    chk("R5 accesses = reads+writes", 64'(acc), 64'(2 * n));
    // enable held high: nothing more happens (R1, R7)
    for (int g = 0; g < 8; g++) begin
      @(negedge clk);
      if (busy || !done) begin
        chk("R1 no restart while held", 64'(busy), 64'd0);
        break;
      end
    end
    chk("R1 no access while held", 64'(acc), 64'(2 * n));
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #5;
    @(negedge clk);
    chk("R6 reset done", 64'(done), 64'd1);
    chk("R6 reset busy", 64'(busy), 64'd0);
    chk("R6 reset port quiet", 64'(req), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R6 idle after reset", 64'({busy, done}), 64'b01);

    // R3 raw LFSR: full enables, masks neutral
    run_fill(0, 63, 32'h7FFF_FFFF, '1, '0, '1, 1, 0);
    run_fill(5, 5, 32'h0000_0001, '1, '0, '1, 2, 0);
    // R4 overlapping masks, AND wins
    run_fill(10, 20, 32'hDEAD_BEEF, '1, 32'hF0F0_FF00, 32'hFF00_F0F0, 3, 0);
    // R5 partial bit enables
    run_fill(17, 40, 32'h1234_5678, 32'h0FF0_33C3, 32'h0000_FFFF, 32'hFFFF_0FFF, 4, 0);
    // boundaries
    run_fill(0, 0, 32'hFFFF_FFFF, 32'hFFFF_0000, '0, '1, 5, 0);
    run_fill(63, 63, 32'h8000_0000, '1, 32'h1, '1, 6, 0);
    // R7 empty window
    run_fill(30, 12, 32'hCAFE_F00D, '1, '0, '1, 7, 0);
    run_fill(1, 0, 32'h1, '1, '0, '1, 8, 0);
    // R8 config scrambled during fill
    run_fill(8, 31, 32'hA5A5_0F0F, 32'h00FF_FF00, 32'h0001_0000, 32'hFFFE_FFFF, 9, 1);
    // R1 re-rise while busy
    run_fill(2, 12, 32'h0BAD_CAFE, '1, '0, '1, 10, 2);
    // R1 re-rise on the last write edge
    run_fill(40, 47, 32'h7777_1111, 32'hF0F0_F0F0, 32'h0F00_0000, '1, 11, 3);
    run_fill(50, 50, 32'h0000_00FF, '1, '0, '1, 12, 3);
    // sweep of small windows
    for (int s = 0; s < DEPTH; s += 9) begin
      run_fill(s, (s + 3 < DEPTH) ? s + 3 : DEPTH - 1, 32'h1000_0001 + 32'(s),
               32'hFFFF_FF0F, 32'(s << 4), ~32'(s), 20 + s, 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule